// File: doc/BRIEF.md
# Object Handle Hash Lookup

This block turns a 32-bit object handle and a channel number into the location of the object's instance record. The location is an engine identifier and an offset counted from the base of instance memory. The pairs live in a local table RAM of 2048 slots, 64 bits each. A slot's index comes from an XOR fold of the handle that also mixes in the channel. When a slot holds some other handle, the block walks forward through the slots with linear probing.

A client presents one request at a time: a lookup or an insert, with the handle, the channel and, for an insert, the engine and offset. The block takes the request only while it is idle. It answers with a single-cycle response strobe that carries hit, table-full, engine and offset. After reset the block sweeps the whole table to empty before it takes its first request.

Top module: `handle_lookup`

## Requirements
- R1: After reset the block writes every slot to empty, one slot per cycle. `req_ready` stays low for exactly 2048 cycles after reset is released and then goes high. Every lookup made after that misses until something is inserted.
- R2: The first slot probed has index `(handle ^ handle>>11 ^ handle>>22 ^ channel<<7) & 0x7ff`.
- R3: A slot packs the handle in bits 63:32, the engine in bits 31:20 and the offset in bits 19:0. The offset is stored and returned unchanged, as a value relative to the base of instance memory.
- R4: A lookup that reaches a slot holding its handle responds with `rsp_hit`=1 and that slot's engine and offset.
- R5: A lookup that reaches an empty slot, or that has probed all 2048 slots without a match, responds with `rsp_hit`=0, `rsp_full`=0, and engine and offset zero.
- R6: A request with handle zero leaves the table unchanged and responds in the cycle after it is accepted with hit=0 and full=0. `req_ready` stays high.
- R7: An insert that reaches an empty slot writes the entry and responds with hit=0. An insert that reaches its own handle overwrites engine and offset and responds with hit=1. In both cases the response echoes the written engine and offset.
- R8: When a probed slot holds a different nonzero handle, the next probe goes to index+1 modulo 2048, so the probe after 2047 is 0.
- R9: An insert that probes all 2048 slots without finding its handle or an empty slot responds with `rsp_full`=1 and hit=0 and writes nothing. `rsp_hit` and `rsp_full` are never both high, and `rsp_full` is only ever set on an insert.
- R10: Each probe takes one cycle. A nonzero request that needs p probes drives `rsp_valid` high for one cycle, p clock edges after the edge that accepted it. `req_ready` is low from acceptance until the response, and it is high while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 1 | 0 = lookup, 1 = insert |
| req_handle | input | 32 | Object handle |
| req_chan | input | CHAN_W (4) | Channel number |
| req_engine | input | 12 | Engine identifier to store (insert) |
| req_offset | input | 20 | Instance-memory offset to store (insert) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Handle was found in the table |
| rsp_full | output | 1 | Insert failed because no slot was free |
| rsp_engine | output | 12 | Engine identifier of the result |
| rsp_offset | output | 20 | Instance offset of the result |

## Verification
The assertions check the handshake on every cycle. They cover the clear period after reset, busy-after-accept, ready-during-response, the immediate miss for handle zero, the exclusivity of hit and full, full appearing only on inserts, and the 2048-probe ceiling on latency. Only the bench's scenarios can show the table contents. That covers correct hash indices, the wraparound from slot 2047 to slot 0, collision chains across channels, overwrite on re-insert, the clearing done by a later reset, and full or miss answers on a completely filled table. The bench confirms these by matching probe counts and returned fields against a reference model.

// File: rtl/hlk_pkg.sv
package hlk_pkg;
  localparam int HANDLE_W = 32;
  localparam int ENGINE_W = 12;
  localparam int OFFSET_W = 20;
  localparam int ENTRY_W  = HANDLE_W + ENGINE_W + OFFSET_W;

  localparam logic OP_LOOKUP = 1'b0;
  localparam logic OP_INSERT = 1'b1;

  // slot layout: handle in the top word, engine above offset in the low word
  typedef struct packed {
    logic [HANDLE_W-1:0] handle;
    logic [ENGINE_W-1:0] engine;
    logic [OFFSET_W-1:0] offset;
  } slot_t;
endpackage

// File: rtl/hlk_hash.sv
module hlk_hash #(
  parameter int IDX_W  = 11,
  parameter int CHAN_W = 4
) (
  input  logic [hlk_pkg::HANDLE_W-1:0] handle,
  input  logic [CHAN_W-1:0]            chan,
  output logic [IDX_W-1:0]             idx
);
  localparam int HW = hlk_pkg::HANDLE_W;
  logic [HW-1:0] chan_ext;
  logic [HW-1:0] folded;

  always_comb begin
    chan_ext = HW'(chan);
    folded   = handle ^ (handle >> 11) ^ (handle >> 22) ^ (chan_ext << 7);
    idx      = folded[IDX_W-1:0];
  end
endmodule

// File: rtl/hlk_table_ram.sv
module hlk_table_ram #(
  parameter int IDX_W = 11,
  parameter int W     = 64
) (
  input  logic             clk,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hlk_probe_fsm.sv
module hlk_probe_fsm
  import hlk_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_op,
  input  logic [HANDLE_W-1:0] req_handle,
  input  logic [ENGINE_W-1:0] req_engine,
  input  logic [OFFSET_W-1:0] req_offset,
  input  logic [IDX_W-1:0]    hash_idx,
  input  slot_t               rd_slot,
  output logic                req_ready,
  output logic                ram_re,
  output logic [IDX_W-1:0]    ram_raddr,
  output logic                ram_we,
  output logic [IDX_W-1:0]    ram_waddr,
  output slot_t               ram_wdata,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_full,
  output logic [ENGINE_W-1:0] rsp_engine,
  output logic [OFFSET_W-1:0] rsp_offset
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;

  typedef enum logic [1:0] {ST_CLEAR, ST_IDLE, ST_PROBE} state_t;

  state_t              state;
  logic [IDX_W-1:0]    idx;
  logic [CNT_W-1:0]    cnt;
  logic                op_q;
  logic [HANDLE_W-1:0] handle_q;
  logic [ENGINE_W-1:0] engine_q;
  logic [OFFSET_W-1:0] offset_q;

  logic accept, zero_req, slot_match, slot_empty, last_probe, stop;

  always_comb begin
    accept     = (state == ST_IDLE) && req_valid;
    zero_req   = (req_handle == '0);
    slot_match = (rd_slot.handle == handle_q);
    slot_empty = (rd_slot.handle == '0);
    last_probe = (cnt == CNT_W'(DEPTH - 1));
    stop       = slot_match || slot_empty;
    req_ready  = (state == ST_IDLE);

    ram_raddr  = (state == ST_IDLE) ? hash_idx : idx + 1'b1;
    ram_re     = (accept && !zero_req) ||
                 ((state == ST_PROBE) && !stop && !last_probe);

    ram_we     = (state == ST_CLEAR) ||
                 ((state == ST_PROBE) && (op_q == OP_INSERT) && stop);
    ram_waddr  = idx;
    ram_wdata  = (state == ST_CLEAR) ? slot_t'('0)
                                     : slot_t'{handle: handle_q, engine: engine_q, offset: offset_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      idx        <= '0;
      cnt        <= '0;
      op_q       <= OP_LOOKUP;
      handle_q   <= '0;
      engine_q   <= '0;
      offset_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_full   <= 1'b0;
      rsp_engine <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(DEPTH - 1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            op_q     <= req_op;
            handle_q <= req_handle;
            engine_q <= req_engine;
            offset_q <= req_offset;
            if (zero_req) begin
              rsp_valid  <= 1'b1;
              rsp_hit    <= 1'b0;
              rsp_full   <= 1'b0;
              rsp_engine <= '0;
              rsp_offset <= '0;
            end else begin
              idx   <= hash_idx;
              cnt   <= '0;
              state <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          if (stop) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= slot_match;
            rsp_full  <= 1'b0;
            if (op_q == OP_INSERT) begin
              rsp_engine <= engine_q;
              rsp_offset <= offset_q;
            end else begin
              rsp_engine <= slot_match ? rd_slot.engine : '0;
              rsp_offset <= slot_match ? rd_slot.offset : '0;
            end
            state <= ST_IDLE;
          end else if (last_probe) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_full   <= (op_q == OP_INSERT);
            rsp_engine <= '0;
            rsp_offset <= '0;
            state      <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/handle_lookup.sv
module handle_lookup
  import hlk_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int CHAN_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic [HANDLE_W-1:0] req_handle,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic [ENGINE_W-1:0] req_engine,
  input  logic [OFFSET_W-1:0] req_offset,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_full,
  output logic [ENGINE_W-1:0] rsp_engine,
  output logic [OFFSET_W-1:0] rsp_offset
);
  logic [IDX_W-1:0]   hash_idx;
  logic               ram_re, ram_we;
  logic [IDX_W-1:0]   ram_raddr, ram_waddr;
  logic [ENTRY_W-1:0] ram_rdata;
  slot_t              ram_wdata;

  hlk_hash #(.IDX_W(IDX_W), .CHAN_W(CHAN_W)) u_hash (
    .handle(req_handle),
    .chan  (req_chan),
    .idx   (hash_idx)
  );

  hlk_table_ram #(.IDX_W(IDX_W), .W(ENTRY_W)) u_ram (
    .clk  (clk),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata)
  );

  hlk_probe_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_handle(req_handle),
    .req_engine(req_engine),
    .req_offset(req_offset),
    .hash_idx  (hash_idx),
    .rd_slot   (slot_t'(ram_rdata)),
    .req_ready (req_ready),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_full  (rsp_full),
    .rsp_engine(rsp_engine),
    .rsp_offset(rsp_offset)
  );
endmodule

// File: rtl/hlk_checker.sv
module hlk_checker #(
  parameter int IDX_W = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_op,
  input logic [31:0] req_handle,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_full
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = IDX_W + 2;

  logic [CW-1:0] clr_cnt;
  logic [CW-1:0] probe_cnt;
  logic          op_last;
  logic          accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_cnt   <= '0;
      probe_cnt <= '0;
      op_last   <= 1'b0;
    end else begin
      if (clr_cnt != CW'(DEPTH)) clr_cnt <= clr_cnt + 1'b1;
      if (accept) begin
        probe_cnt <= '0;
        op_last   <= req_op;
      end else if (!req_ready && clr_cnt == CW'(DEPTH) && probe_cnt != '1) begin
        probe_cnt <= probe_cnt + 1'b1;
      end
    end
  end

  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
    (clr_cnt < CW'(DEPTH)) |-> !req_ready); // R1

  AST_ZERO_HANDLE_MISS: assert property (@(posedge clk) disable iff (rst)
    (accept && req_handle == '0) |=> (rsp_valid && !rsp_hit && !rsp_full && req_ready)); // R6

  AST_HIT_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_hit && rsp_full)); // R9

  AST_FULL_ON_INSERT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_full) |-> op_last); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (accept && req_handle != '0) |=> (!req_ready && !rsp_valid)); // R10

  AST_READY_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R10

  AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (probe_cnt <= CW'(DEPTH))); // R8
endmodule

bind handle_lookup hlk_checker #(.IDX_W(IDX_W)) u_hlk_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_handle(req_handle),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_full  (rsp_full)
);

// File: tb/handle_lookup_bench.sv
`timescale 1ns/1ps
module handle_lookup_bench;
  localparam int NSLOT = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [31:0] req_handle = '0;
  logic [3:0]  req_chan = '0;
  logic [11:0] req_engine = '0;
  logic [19:0] req_offset = '0;
  logic        rsp_valid, rsp_hit, rsp_full;
  logic [11:0] rsp_engine;
  logic [19:0] rsp_offset;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_h [NSLOT];
  logic [11:0] m_e [NSLOT];
  logic [19:0] m_o [NSLOT];

  always #2.5 clk = ~clk;

  handle_lookup u_handle_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_handle(req_handle), .req_chan(req_chan),
    .req_engine(req_engine), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
    .rsp_engine(rsp_engine), .rsp_offset(rsp_offset)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fold(input logic [31:0] h, input logic [3:0] c);
    logic [31:0] m;
    m = h ^ (h >> 11) ^ (h >> 22) ^ ({28'd0, c} << 7);
    return int'(m[10:0]);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NSLOT; i++) begin
      m_h[i] = '0; m_e[i] = '0; m_o[i] = '0;
    end
  endtask

  task automatic do_reset();
    int n;
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
    chk(rsp_valid == 1'b0, "R10 no response in reset", rsp_valid, 0);
    rst = 1'b0;
    model_clear();
    n = 0;
    while (!req_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == NSLOT, "R1 clear sweep length", n, NSLOT);
  endtask

  // One request, checked against the reference model (R2 R3 R4 R5 R7 R8 R9 R10)
  task automatic req(input logic op, input logic [31:0] h, input logic [3:0] c,
                     input logic [11:0] e, input logic [19:0] o);
    int p, idx, slot, n;
    bit hit, full;
    logic [11:0] xe;
    logic [19:0] xo;
    p = 0; hit = 0; full = 0; xe = '0; xo = '0; slot = -1;
    if (h != 0) begin
      idx = fold(h, c);
      for (int k = 0; k < NSLOT; k++) begin
        p = k + 1;
        if (m_h[idx] == h) begin hit = 1; slot = idx; break; end
        if (m_h[idx] == 0) begin slot = idx; break; end
        idx = (idx + 1) % NSLOT;
      end
      if (op) begin
        if (slot < 0) full = 1;
        else begin
          m_h[slot] = h; m_e[slot] = e; m_o[slot] = o; xe = e; xo = o;
        end
      end else if (hit) begin
        xe = m_e[slot]; xo = m_o[slot];
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_handle = h; req_chan = c;
    req_engine = e; req_offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, "R10 response seen", rsp_valid, 1);
    chk(n == p, "R10 probe latency", n, p);
    chk(rsp_hit == hit, "R4 R7 hit flag", rsp_hit, hit);
    chk(rsp_full == full, "R9 full flag", rsp_full, full);
    chk(rsp_engine == xe, "R3 engine field", rsp_engine, xe);
    chk(rsp_offset == xo, "R3 offset field", rsp_offset, xo);
    chk(req_ready == 1'b1, "R10 ready at response", req_ready, 1);
    @(negedge clk);
    if (!req_valid)
      chk(rsp_valid == 1'b0, "R10 single-cycle strobe", rsp_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pool [12];
    void'($urandom(32'h1234_5678));
    model_clear();
    do_reset();

    // R5: empty table misses on first probe
    req(1'b0, 32'h3137_c0de, 4'd2, '0, '0);
    req(1'b0, 32'h0000_0100, 4'd0, '0, '0);

    // R2 R4 R7: insert and look up; offset returned unchanged (R3)
    req(1'b1, 32'h0000_0100, 4'd0, 12'h040, 20'h1_0010);
    req(1'b0, 32'h0000_0100, 4'd0, '0, '0);
    // R8 collision: 0x80 on channel 3 folds to 0x100 as well, so two probes
    req(1'b1, 32'h0000_0080, 4'd3, 12'h097, 20'h0_2000);
    req(1'b0, 32'h0000_0080, 4'd3, '0, '0);
    // R8 wraparound: slot 0x7ff taken, next probe lands in slot 0
    req(1'b1, 32'h0000_07ff, 4'd0, 12'h001, 20'h0_0700);
    req(1'b1, 32'h0000_077f, 4'd1, 12'h002, 20'h0_0800);
    req(1'b0, 32'h0000_077f, 4'd1, '0, '0);
    // R2: handles whose upper bits feed the fold
    req(1'b1, 32'h0040_0800, 4'd5, 12'h3aa, 20'hf_ffff);
    req(1'b0, 32'h0040_0800, 4'd5, '0, '0);
    req(1'b0, 32'h0040_0800, 4'd6, '0, '0);
    // R7 overwrite of an existing handle
    req(1'b1, 32'h0000_0100, 4'd0, 12'h555, 20'h5_5555);
    req(1'b0, 32'h0000_0100, 4'd0, '0, '0);
    // R6 handle zero: immediate miss, table untouched
    req(1'b1, 32'h0, 4'd0, 12'hfff, 20'hf_ffff);
    req(1'b0, 32'h0, 4'd7, '0, '0);
    req(1'b0, 32'h0000_0100, 4'd0, '0, '0);

    // constrained random mix over a small handle pool, forcing collisions
    for (int i = 0; i < 12; i++) pool[i] = (i == 11) ? 32'h0 : $urandom();
    pool[3] = 32'h0000_0180;
    pool[4] = 32'h0000_0100;
    for (int i = 0; i < 400; i++)
      req(1'($urandom_range(0, 1)), pool[$urandom_range(0, 11)], 4'($urandom_range(0, 3)),
          12'($urandom()), 20'($urandom()));

    // R1: a later reset empties the table
    do_reset();
    req(1'b0, 32'h0000_0100, 4'd0, '0, '0);

    // R9: fill every slot, one probe each, then overflow
    for (int i = 1; i < NSLOT; i++)
      req(1'b1, 32'(i), 4'd0, 12'(i), 20'(i * 3));
    req(1'b1, 32'h0000_0801, 4'd0, 12'h801, 20'h0_0801);
    req(1'b1, 32'h0001_2345, 4'd2, 12'h123, 20'h4_5678);
    req(1'b0, 32'h0001_2345, 4'd2, '0, '0);   // R5 miss after full sweep
    req(1'b0, 32'h0000_0801, 4'd0, '0, '0);
    req(1'b1, 32'h0000_0005, 4'd0, 12'h0aa, 20'h0_00bb); // R7 overwrite when full

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule